// File: doc/BRIEF.md
# Master/Checker Redundancy Comparator

This block sits between the internal logic of a bus-interface unit and its output pad drivers, and lets two identical units run in lockstep. A strap input picks the unit's role when it leaves reset. As the master, the unit drives its pads normally. As the checker, it drives none of its pads except an error flag and a test-data output. It reads back the pad values that the master drives, compares them against its own internally computed values, and flags any difference on the error output.

The error output is active low and idles high. It also reports parity errors that internal arrays signal on a strobe. A parity error produces a single one-clock low pulse and then a shutdown request, which stays asserted until the next reset. Parity generation and the shutdown sequence itself belong to other blocks.

Top module: `mc_guard`

## Requirements
- R1: The role strap `role_strap_i` (1 = checker, 0 = master) is captured on the first rising clock edge after `rst_ni` deasserts. Later changes of the strap have no effect until the next reset.
- R2: The following hold while `rst_ni` is low and up to that first capture edge: every `pin_oe_o` bit is 0, `err_no` is 1 and `shutdown_o` is 0.
- R3: In master role, `pin_val_o` equals `core_val_i` and `pin_oe_o` equals `core_oe_i` in the same cycle. No pin difference ever pulls `err_no` low.
- R4: In checker role, every `pin_oe_o` bit is 0. In both roles, `tdo_oe_o` is 1 and `tdo_o` follows `tdo_core_i`, and `err_no` is always driven.
- R5: In checker role, take inputs sampled at rising edge k where `pin_in_i` differs from `core_val_i` in any bit whose `core_oe_i` bit is 1. Then `err_no` is low for the one cycle between edge k+2 and edge k+3. Mismatches on consecutive edges give consecutive low cycles.
- R6: Bits whose `core_oe_i` bit is 0 are left out of the comparison, so a difference confined to those bits leaves `err_no` high.
- R7: The first `par_err_i` high sampled at edge k pulls `err_no` low for exactly the cycle between edges k and k+1, even if the strobe stays high. `shutdown_o` rises at edge k+1.
- R8: Once set, `shutdown_o` stays high until reset. Parity strobes after the first have no effect on `err_no`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| role_strap_i | input | 1 | Role select, 1 = checker, captured after reset |
| core_val_i | input | W | Internally computed output values |
| core_oe_i | input | W | Internally computed driver enables |
| pin_in_i | input | W | Values sampled back from the pads |
| tdo_core_i | input | 1 | Internal test-data output value |
| par_err_i | input | 1 | Parity-error strobe from internal arrays |
| pin_val_o | output | W | Values to the pad drivers |
| pin_oe_o | output | W | Enables to the pad drivers |
| tdo_o | output | 1 | Test-data output value |
| tdo_oe_o | output | 1 | Test-data driver enable |
| err_no | output | 1 | Error flag, active low |
| shutdown_o | output | 1 | Sticky shutdown request |

## Verification
The assertions assume that the strap is settled by the capture edge. They also assume that the pad read-back in checker role reflects the other unit's values in the same cycle as the local values, and that `par_err_i` is a synchronous strobe. The stimulus changes inputs only on falling edges and keeps the strap steady across each release of reset. Read-back values match the local values except on the cycles that deliberately inject one- or two-bit differences. The parity strobe is raised only after the role has been captured, and in one case it is held high to confirm that only one pulse results.

// File: rtl/mc_guard_pkg.sv
package mc_guard_pkg;
  typedef enum logic {
    ROLE_MASTER  = 1'b0,
    ROLE_CHECKER = 1'b1
  } role_e;
endpackage

// File: rtl/mc_role_latch.sv
module mc_role_latch
  import mc_guard_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  strap_i,
  output logic  locked_o,
  output role_e role_o
);
  logic  lock_q;
  role_e role_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      role_q <= ROLE_MASTER;
    end else if (!lock_q) begin
      lock_q <= 1'b1;
      role_q <= role_e'(strap_i);
    end
  end

  assign locked_o = lock_q;
  assign role_o   = role_q;

  assert_role_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && $past(lock_q)) |-> $stable(role_q));
  assert_lock_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
endmodule

// File: rtl/mc_out_gate.sv
module mc_out_gate
  import mc_guard_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         locked_i,
  input  role_e        role_i,
  input  logic [W-1:0] core_val_i,
  input  logic [W-1:0] core_oe_i,
  input  logic         tdo_core_i,
  output logic [W-1:0] pin_val_o,
  output logic [W-1:0] pin_oe_o,
  output logic         tdo_o,
  output logic         tdo_oe_o
);
  logic drive_en;
  assign drive_en = locked_i && (role_i == ROLE_MASTER);

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign pin_val_o[b] = core_val_i[b];
    assign pin_oe_o[b]  = core_oe_i[b] & drive_en;
  end

  // test-data pad is exempt from checker tristate
  assign tdo_o    = tdo_core_i;
  assign tdo_oe_o = 1'b1;

  assert_quiet_before_lock_R2: assert property (@(posedge clk_i)
    !locked_i |-> (pin_oe_o == '0));
  assert_checker_no_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && role_i == ROLE_CHECKER) |-> (pin_oe_o == '0));
  assert_master_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && role_i == ROLE_MASTER) |-> (pin_oe_o == core_oe_i));
endmodule

// File: rtl/mc_cmp_pipe.sv
module mc_cmp_pipe #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         chk_en_i,
  input  logic [W-1:0] core_val_i,
  input  logic [W-1:0] core_oe_i,
  input  logic [W-1:0] pin_in_i,
  output logic         mis_o
);
  logic         chk_q;
  logic [W-1:0] val_q, oe_q, pin_q;
  logic [W-1:0] diff;
  logic         mis_q;

  // stage 1: capture both sides of the comparison
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= 1'b0;
      val_q <= '0;
      oe_q  <= '0;
      pin_q <= '0;
    end else begin
      chk_q <= chk_en_i;
      val_q <= core_val_i;
      oe_q  <= core_oe_i;
      pin_q <= pin_in_i;
    end
  end

  assign diff = (val_q ^ pin_q) & oe_q;

  // stage 2: reduce
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mis_q <= 1'b0;
    else         mis_q <= chk_q && (|diff);
  end

  assign mis_o = mis_q;

  assert_no_mis_in_master_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_q |=> !mis_q);
  assert_masked_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((val_q ^ pin_q) & oe_q) == '0) |=> !mis_q);
endmodule

// File: rtl/mc_err_ctl.sv
module mc_err_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mis_i,
  input  logic par_err_i,
  output logic err_no,
  output logic shutdown_o
);
  logic mis_err_q, par_pulse_q, sd_q;
  logic par_done;

  // only the first parity strobe per reset produces a pulse
  assign par_done = par_pulse_q | sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mis_err_q   <= 1'b0;
      par_pulse_q <= 1'b0;
      sd_q        <= 1'b0;
    end else begin
      mis_err_q   <= mis_i;
      par_pulse_q <= par_err_i && !par_done;
      sd_q        <= sd_q | par_pulse_q;
    end
  end

  assign err_no     = ~(mis_err_q | par_pulse_q);
  assign shutdown_o = sd_q;

  assert_mis_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_i |=> !err_no);
  assert_par_sd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_pulse_q |=> shutdown_o);
  assert_par_one_clk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_pulse_q |=> !par_pulse_q);
  assert_sd_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> shutdown_o);
endmodule

// File: rtl/mc_guard.sv
module mc_guard
  import mc_guard_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         role_strap_i,
  input  logic [W-1:0] core_val_i,
  input  logic [W-1:0] core_oe_i,
  input  logic [W-1:0] pin_in_i,
  input  logic         tdo_core_i,
  input  logic         par_err_i,
  output logic [W-1:0] pin_val_o,
  output logic [W-1:0] pin_oe_o,
  output logic         tdo_o,
  output logic         tdo_oe_o,
  output logic         err_no,
  output logic         shutdown_o
);
  logic  locked;
  role_e role;
  logic  chk_en;
  logic  mis;

  mc_role_latch u_role (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (role_strap_i),
    .locked_o(locked),
    .role_o  (role)
  );

  mc_out_gate #(.W(W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .locked_i  (locked),
    .role_i    (role),
    .core_val_i(core_val_i),
    .core_oe_i (core_oe_i),
    .tdo_core_i(tdo_core_i),
    .pin_val_o (pin_val_o),
    .pin_oe_o  (pin_oe_o),
    .tdo_o     (tdo_o),
    .tdo_oe_o  (tdo_oe_o)
  );

  assign chk_en = locked && (role == ROLE_CHECKER);

  mc_cmp_pipe #(.W(W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chk_en_i  (chk_en),
    .core_val_i(core_val_i),
    .core_oe_i (core_oe_i),
    .pin_in_i  (pin_in_i),
    .mis_o     (mis)
  );

  mc_err_ctl u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mis_i     (mis),
    .par_err_i (par_err_i),
    .err_no    (err_no),
    .shutdown_o(shutdown_o)
  );

  assert_tdo_driven_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdo_oe_o && (tdo_o == tdo_core_i));
  assert_err_idle_reset_R2: assert property (@(posedge clk_i)
    !locked |-> (err_no && !shutdown_o));
endmodule

// File: tb/sim_mc_guard.sv
`timescale 1ns/1ps
module sim_mc_guard;
  localparam int W = 16;
  localparam logic [W-1:0] VAL = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic [W-1:0] cval = VAL, coe = '1, pin = VAL;
  logic tdo_c = 1'b0, par = 1'b0;
  logic [W-1:0] pval, poe;
  logic tdo, tdo_oe, err_n, sd;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mc_guard #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .role_strap_i(strap),
    .core_val_i(cval), .core_oe_i(coe), .pin_in_i(pin),
    .tdo_core_i(tdo_c), .par_err_i(par),
    .pin_val_o(pval), .pin_oe_o(poe), .tdo_o(tdo), .tdo_oe_o(tdo_oe),
    .err_no(err_n), .shutdown_o(sd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; par = 1'b0; cval = VAL; coe = '1; pin = VAL;
    nedge(2);
    chk(poe == '0, "R2 oe in reset", poe, 0);
    chk(err_n === 1'b1 && sd === 1'b0, "R2 err/sd in reset", {err_n, sd}, 2'b10);
    rst_n = 1'b1;
    #1;
    chk(poe == '0, "R2 oe before capture", poe, 0);
    nedge(1);
  endtask

  task automatic t_master;
    do_reset(1'b0);
    strap = 1'b1;
    nedge(2);
    chk(poe == coe && pval == cval, "R1 R3 master drive after strap change", poe, coe);
    coe = 16'h0F0F; cval = 16'h1234;
    #1;
    chk(poe == 16'h0F0F && pval == 16'h1234, "R3 pass-through", {pval, poe}, {16'h1234, 16'h0F0F});
    pin = 16'hFFFF;
    for (int i = 0; i < 4; i++) begin
      nedge(1);
      chk(err_n === 1'b1, "R3 no mismatch error in master", err_n, 1);
    end
    pin = VAL; cval = VAL; coe = '1;
    tdo_c = 1'b1; #1;
    chk(tdo === 1'b1 && tdo_oe === 1'b1, "R4 tdo master", {tdo, tdo_oe}, 2'b11);
  endtask

  task automatic t_checker_mis;
    do_reset(1'b1);
    strap = 1'b0;
    nedge(1);
    chk(poe == '0, "R1 R4 checker tristate", poe, 0);
    tdo_c = 1'b0; #1;
    chk(tdo === 1'b0 && tdo_oe === 1'b1, "R4 tdo checker", {tdo, tdo_oe}, 2'b01);
    pin = VAL ^ 16'h0080;
    nedge(1); pin = VAL;
    chk(err_n === 1'b1, "R5 not yet k+1", err_n, 1);
    nedge(1);
    chk(err_n === 1'b1, "R5 not yet k+2 edge", err_n, 1);
    nedge(1);
    chk(err_n === 1'b0, "R5 low after k+2", err_n, 0);
    nedge(1);
    chk(err_n === 1'b1, "R5 high after k+3", err_n, 1);
    // two consecutive mismatches
    pin = VAL ^ 16'h8001;
    nedge(2); pin = VAL;
    nedge(1);
    chk(err_n === 1'b0, "R5 consecutive first", err_n, 0);
    nedge(1);
    chk(err_n === 1'b0, "R5 consecutive second", err_n, 0);
    nedge(1);
    chk(err_n === 1'b1, "R5 consecutive end", err_n, 1);
  endtask

  task automatic t_mask;
    do_reset(1'b1);
    nedge(1);
    coe = 16'hFFFE; pin = VAL ^ 16'h0001;
    nedge(1); coe = '1; pin = VAL;
    for (int i = 0; i < 3; i++) begin
      nedge(1);
      chk(err_n === 1'b1, "R6 masked bit ignored", err_n, 1);
    end
  endtask

  task automatic t_parity;
    do_reset(1'b0);
    par = 1'b1;
    nedge(1);
    chk(err_n === 1'b0 && sd === 1'b0, "R7 pulse after k", {err_n, sd}, 2'b00);
    nedge(1);
    chk(err_n === 1'b1 && sd === 1'b1, "R7 one clock then shutdown", {err_n, sd}, 2'b11);
    nedge(2); par = 1'b0;
    chk(err_n === 1'b1 && sd === 1'b1, "R8 held strobe no second pulse", {err_n, sd}, 2'b11);
    nedge(2); par = 1'b1;
    nedge(1); par = 1'b0;
    chk(err_n === 1'b1, "R8 later strobe ignored", err_n, 1);
    nedge(3);
    chk(sd === 1'b1, "R8 shutdown sticky", sd, 1);
    do_reset(1'b0);
    chk(sd === 1'b0, "R8 cleared by reset", sd, 0);
  endtask

  initial begin
    t_master();
    t_checker_mis();
    t_mask();
    t_parity();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule